// File: doc/BRIEF.md
# Low-Transition Memory Test Address Generator

This block supplies the address stream that a memory self-test controller uses to visit every location of the memory under test. A modulo counter feeds a binary-to-Gray encoder, so each step of the walk flips a single address bit and the address lines toggle far less than they would with a linear feedback register or a plain binary count. The counter stops one value short of the full range. The one remaining address, a one in the most significant position, is never counted: it is formed by mirroring the constant 00…01 through a bit-reversal path. The walk therefore covers all 2^N addresses, including all-zero, each exactly once.

The controller pulses `start_i` to begin a pass, choosing ascending or descending order with `descend_i`. It then pulses `advance_i` once per memory access. `addr_valid_o` stays high from the first start onward. `addr_last_o` marks the final address of the pass, and the generator holds that address until the next start. The controller typically runs one pass for writes and a second pass for reads.

Top module: `lta_addr_gen`

## Requirements
- R1: While reset is active, and until the first start, `addr_o` is all zeros and both `addr_valid_o` and `addr_last_o` are low.
- R2: A start pulse with `descend_i` low makes `addr_o` equal all zeros and raises `addr_valid_o` at the same clock edge that samples the start.
- R3: In ascending order, each advance pulse moves the internal count c up by one, from 0 to 2^N−2, and `addr_o` equals c XOR (c >> 1).
- R4: In ascending order, the advance taken at count 2^N−2 gives the address with only bit N−1 set (00…01 mirrored) and raises `addr_last_o`.
- R5: In ascending order, any two consecutive addresses differ in exactly one bit, including the step onto the mirrored address.
- R6: One ascending pass presents all 2^N addresses, each exactly once.
- R7: A start pulse with `descend_i` high presents the mirrored address first. Each following advance then gives the Gray codes of counts 2^N−2 down to 0, and `addr_last_o` rises with address zero.
- R8: While `addr_last_o` is high, advance pulses are ignored, and address and flags hold until the next start.
- R9: A start pulse during a pass restarts the walk from its first address, in the order that `descend_i` selects at that edge.
- R10: An advance pulse before the first start has no effect.
- R11: When start and advance are high in the same cycle, the start takes effect and the advance is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Begins a new pass, sampled on the rising clock edge |
| advance_i | input | 1 | Steps to the next address |
| descend_i | input | 1 | Order select sampled together with start: 1 selects descending |
| addr_o | output | ADDR_W | Current test address |
| addr_valid_o | output | 1 | Address is meaningful (high from the first start onward) |
| addr_last_o | output | 1 | Current address is the final one of the pass |

## Verification
The bench builds the block at the default width of 10 bits. At that width the step from count 2^N−2, whose code 1000000001 is its own mirror image, onto the mirrored address 1000000000 is exercised, and a complete pass of 1024 addresses fits well inside the run. Ascending passes with steady and with gapped advance pulses, a descending pass, restarts in mid-pass and a start that collides with an advance are all compared every cycle against a behavioural model. Complete coverage and the single-bit step property are also tallied over a whole pass.

// File: rtl/lta_pkg.sv
package lta_pkg;

  // Walk phase: idle until the first start, counting through Gray codes,
  // or presenting the mirrored address.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_COUNT = 2'd1,
    PH_REV   = 2'd2
  } lta_phase_e;

endpackage

// File: rtl/lta_rst_sync.sv
module lta_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/lta_mod_counter.sv
module lta_mod_counter #(
  parameter int unsigned W = 10,
  parameter logic [W-1:0] MAX_VAL = {{(W-1){1'b1}}, 1'b0}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         up_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o,
  output logic         at_max_o,
  output logic         at_zero_o,
  output logic         nxt_zero_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_ce;

  // Next-state: load wins over counting; counting wraps at the modulus.
  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (en_i) begin
      if (up_i) begin
        cnt_d = (cnt_q == MAX_VAL) ? '0 : cnt_q + W'(1);
      end else begin
        cnt_d = (cnt_q == '0) ? MAX_VAL : cnt_q - W'(1);
      end
    end
  end

  assign cnt_ce = load_i | en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign cnt_nxt_o  = cnt_d;
  assign at_max_o   = (cnt_q == MAX_VAL);
  assign at_zero_o  = (cnt_q == '0);
  assign nxt_zero_o = (cnt_d == '0);

  // R3: a counting step upward below the modulus adds exactly one
  a_r3_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && up_i && !load_i && cnt_q != MAX_VAL) |=> (cnt_q == $past(cnt_q) + W'(1)));

  // R7: a counting step downward above zero subtracts exactly one
  a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !up_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

  // R3: the count never leaves the modulo range
  a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAX_VAL);

endmodule

// File: rtl/lta_gray_enc.sv
module lta_gray_enc #(
  parameter int unsigned W = 10
) (
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] gray_o
);

  // Each code bit is the XOR of a count bit and its upper neighbour.
  for (genvar g = 0; g < W; g++) begin : g_bit
    if (g == W - 1) begin : g_top
      assign gray_o[g] = bin_i[g];
    end else begin : g_mid
      assign gray_o[g] = bin_i[g] ^ bin_i[g+1];
    end
  end

endmodule

// File: rtl/lta_bit_rev.sv
module lta_bit_rev #(
  parameter int unsigned W = 10
) (
  input  logic [W-1:0] src_i,
  output logic [W-1:0] mirror_o
);

  for (genvar m = 0; m < W; m++) begin : g_swap
    assign mirror_o[m] = src_i[W-1-m];
  end

endmodule

// File: rtl/lta_seq_ctrl.sv
module lta_seq_ctrl
  import lta_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       advance_i,
  input  logic       descend_i,
  input  logic       cnt_at_max_i,
  input  logic       cnt_at_zero_i,
  input  logic       cnt_nxt_zero_i,
  output logic       cnt_en_o,
  output logic       cnt_up_o,
  output logic       cnt_load_o,
  output logic       cnt_load_max_o,
  output lta_phase_e phase_nxt_o,
  output logic       desc_q_o,
  output logic       valid_nxt_o,
  output logic       last_nxt_o,
  output logic       out_ce_o
);

  lta_phase_e phase_q;
  lta_phase_e phase_d;
  logic       desc_q;
  logic       desc_d;
  logic       state_ce;

  // Next-state for the walk. Start always wins; an advance is acted upon
  // only when the current address is not the final one of the pass.
  always_comb begin
    phase_d        = phase_q;
    desc_d         = desc_q;
    cnt_en_o       = 1'b0;
    cnt_load_o     = 1'b0;
    cnt_load_max_o = 1'b0;
    if (start_i) begin
      desc_d         = descend_i;
      cnt_load_o     = 1'b1;
      cnt_load_max_o = descend_i;
      phase_d        = descend_i ? PH_REV : PH_COUNT;
    end else if (advance_i) begin
      unique case (phase_q)
        PH_COUNT: begin
          if (!desc_q) begin
            if (cnt_at_max_i) begin
              phase_d = PH_REV;
            end else begin
              cnt_en_o = 1'b1;
            end
          end else if (!cnt_at_zero_i) begin
            cnt_en_o = 1'b1;
          end
        end
        PH_REV: begin
          if (desc_q) begin
            phase_d = PH_COUNT;
          end
        end
        default: begin
          phase_d = phase_q;
        end
      endcase
    end
  end

  assign cnt_up_o    = !desc_q;
  assign state_ce    = start_i | advance_i;
  assign out_ce_o    = state_ce;
  assign phase_nxt_o = phase_d;
  assign desc_q_o    = desc_q;
  assign valid_nxt_o = (phase_d != PH_IDLE);
  assign last_nxt_o  = (phase_d == PH_REV && !desc_d) ||
                       (phase_d == PH_COUNT && desc_d && cnt_nxt_zero_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      desc_q  <= 1'b0;
    end else if (state_ce) begin
      phase_q <= phase_d;
      desc_q  <= desc_d;
    end
  end

  // R10: without a start the walk never leaves idle
  a_r10_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && !start_i) |=> (phase_q == PH_IDLE));

  // R9: a start always restarts in the phase that matches the sampled order
  a_r9_restart_phase: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (phase_q == (desc_q ? PH_REV : PH_COUNT)) && (desc_q == $past(descend_i)));

  // R11: counting and loading never happen together
  a_r11_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_en_o && cnt_load_o));

endmodule

// File: rtl/lta_addr_gen.sv
module lta_addr_gen
  import lta_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              advance_i,
  input  logic              descend_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_valid_o,
  output logic              addr_last_o
);

  localparam logic [ADDR_W-1:0] CNT_MAX  = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] SEED_ONE = ADDR_W'(1);

  logic              rst_q_n;
  logic              cnt_en;
  logic              cnt_up;
  logic              cnt_load;
  logic              cnt_load_max;
  logic [ADDR_W-1:0] cnt_load_val;
  logic [ADDR_W-1:0] cnt_cur;
  logic [ADDR_W-1:0] cnt_nxt;
  logic              cnt_at_max;
  logic              cnt_at_zero;
  logic              cnt_nxt_zero;
  logic [ADDR_W-1:0] gray_nxt;
  logic [ADDR_W-1:0] mirror_addr;
  lta_phase_e        phase_nxt;
  logic              desc_q;
  logic              valid_nxt;
  logic              last_nxt;
  logic              out_ce;
  logic [ADDR_W-1:0] addr_d;
  logic [ADDR_W-1:0] addr_q;
  logic              valid_q;
  logic              last_q;

  lta_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  lta_seq_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_q_n),
    .start_i        (start_i),
    .advance_i      (advance_i),
    .descend_i      (descend_i),
    .cnt_at_max_i   (cnt_at_max),
    .cnt_at_zero_i  (cnt_at_zero),
    .cnt_nxt_zero_i (cnt_nxt_zero),
    .cnt_en_o       (cnt_en),
    .cnt_up_o       (cnt_up),
    .cnt_load_o     (cnt_load),
    .cnt_load_max_o (cnt_load_max),
    .phase_nxt_o    (phase_nxt),
    .desc_q_o       (desc_q),
    .valid_nxt_o    (valid_nxt),
    .last_nxt_o     (last_nxt),
    .out_ce_o       (out_ce)
  );

  assign cnt_load_val = cnt_load_max ? CNT_MAX : '0;

  lta_mod_counter #(
    .W       (ADDR_W),
    .MAX_VAL (CNT_MAX)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .en_i       (cnt_en),
    .up_i       (cnt_up),
    .load_i     (cnt_load),
    .load_val_i (cnt_load_val),
    .cnt_o      (cnt_cur),
    .cnt_nxt_o  (cnt_nxt),
    .at_max_o   (cnt_at_max),
    .at_zero_o  (cnt_at_zero),
    .nxt_zero_o (cnt_nxt_zero)
  );

  lta_gray_enc #(.W(ADDR_W)) u_gray (
    .bin_i  (cnt_nxt),
    .gray_o (gray_nxt)
  );

  lta_bit_rev #(.W(ADDR_W)) u_rev (
    .src_i    (SEED_ONE),
    .mirror_o (mirror_addr)
  );

  // Address source select: mirrored seed in the reversal phase, else Gray.
  always_comb begin
    addr_d = gray_nxt;
    if (phase_nxt == PH_REV) begin
      addr_d = mirror_addr;
    end
  end

  // Registered outputs so the address pins toggle only on real steps.
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (out_ce) begin
      addr_q  <= addr_d;
      valid_q <= valid_nxt;
      last_q  <= last_nxt;
    end
  end

  assign addr_o       = addr_q;
  assign addr_valid_o = valid_q;
  assign addr_last_o  = last_q;

  // R5: ascending steps flip exactly one address bit
  a_r5_one_bit_step: assert property (@(posedge clk) disable iff (!rst_q_n)
    (valid_q && $past(valid_q) && !desc_q && !$past(start_i) && addr_q != $past(addr_q))
      |-> ($countones(addr_q ^ $past(addr_q)) == 1));

  // R4: the ascending pass ends on the mirrored seed
  a_r4_last_mirror: assert property (@(posedge clk) disable iff (!rst_q_n)
    (last_q && !desc_q) |-> (addr_q == {1'b1, {(ADDR_W-1){1'b0}}}));

  // R7: the descending pass ends on address zero
  a_r7_last_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    (last_q && desc_q) |-> (addr_q == '0));

  // R8: the final address holds until a start arrives
  a_r8_hold_at_last: assert property (@(posedge clk) disable iff (!rst_q_n)
    (last_q && !start_i) |=> ($stable(addr_q) && last_q && valid_q));

  // R1: no valid address before the first start
  a_r1_no_early_valid: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!valid_q && !start_i) |=> (!valid_q && addr_q == '0 && !last_q));

  // R2: an ascending start lands on address zero
  a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start_i && !descend_i) |=> (valid_q && addr_q == '0 && !last_q));

endmodule

// File: tb/test_lta_addr_gen.sv
`timescale 1ns/1ps
module test_lta_addr_gen;

  localparam int W     = 10;
  localparam int NADDR = 1 << W;

  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic         advance_i;
  logic         descend_i;
  logic [W-1:0] addr_o;
  logic         addr_valid_o;
  logic         addr_last_o;

  int n_cmp;
  int n_bad;
  int cycles;

  // behavioural model state
  bit m_act;
  bit m_desc;
  int m_idx;

  lta_addr_gen #(.ADDR_W(W)) i_lta_addr_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .advance_i    (advance_i),
    .descend_i    (descend_i),
    .addr_o       (addr_o),
    .addr_valid_o (addr_valid_o),
    .addr_last_o  (addr_last_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Expected address at position i of a pass, taken from the requirements.
  function automatic logic [W-1:0] exp_addr(bit desc, int i);
    int c;
    if (!desc) begin
      if (i == NADDR - 1) return logic'(1) << (W - 1);
      c = i;
    end else begin
      if (i == 0) return logic'(1) << (W - 1);
      c = NADDR - 1 - i;
    end
    return W'(c ^ (c >> 1));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act  = 1'b0;
      m_desc = 1'b0;
      m_idx  = 0;
    end else if (start_i) begin
      m_act  = 1'b1;
      m_desc = descend_i;
      m_idx  = 0;
    end else if (m_act && advance_i && m_idx < NADDR - 1) begin
      m_idx = m_idx + 1;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R1, R3, R7, R8, R9, R11).
  always @(negedge clk) begin
    if (rst_n) begin
      check("R3", "addr",  int'(addr_o), m_act ? int'(exp_addr(m_desc, m_idx)) : 0);
      check("R1", "valid", int'(addr_valid_o), int'(m_act));
      check("R8", "last",  int'(addr_last_o), int'(m_act && m_idx == NADDR - 1));
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  task automatic pulse_start(bit desc, bit with_adv);
    @(negedge clk);
    start_i   = 1'b1;
    descend_i = desc;
    advance_i = with_adv;
    @(negedge clk);
    start_i   = 1'b0;
    advance_i = 1'b0;
  endtask

  task automatic step(int gap);
    advance_i = 1'b1;
    @(negedge clk);
    advance_i = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // One ascending pass: coverage (R6), one-bit steps (R5), final address (R4).
  task automatic full_forward(int gap);
    bit           seen [NADDR];
    int           distinct;
    logic [W-1:0] prev;
    distinct = 0;
    for (int k = 0; k < NADDR; k++) seen[k] = 1'b0;
    pulse_start(1'b0, 1'b0);
    check("R2", "first addr", int'(addr_o), 0);
    for (int k = 0; k < NADDR; k++) begin
      if (seen[addr_o]) check("R6", "repeat addr", int'(addr_o), -1);
      else distinct++;
      seen[addr_o] = 1'b1;
      if (k > 0) check("R5", "bits changed", $countones(addr_o ^ prev), 1);
      prev = addr_o;
      if (k < NADDR - 1) step(gap);
    end
    check("R6", "distinct count", distinct, NADDR);
    check("R4", "final addr", int'(addr_o), 1 << (W - 1));
    check("R4", "last flag", int'(addr_last_o), 1);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; cycles = 0;
    rst_n = 1'b0; start_i = 1'b0; advance_i = 1'b0; descend_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "reset addr",  int'(addr_o), 0);
    check("R1", "reset valid", int'(addr_valid_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: advance before any start
    step(0); step(1);
    check("R10", "idle valid", int'(addr_valid_o), 0);
    check("R10", "idle addr",  int'(addr_o), 0);

    full_forward(0);
    // R8: advances at the last address are ignored
    step(0); step(2);
    check("R8", "held addr", int'(addr_o), 1 << (W - 1));
    check("R8", "held last", int'(addr_last_o), 1);

    full_forward(1);

    // R7: descending pass
    pulse_start(1'b1, 1'b0);
    check("R7", "first desc addr", int'(addr_o), 1 << (W - 1));
    check("R7", "first desc last", int'(addr_last_o), 0);
    step(0);
    check("R7", "second desc addr", int'(addr_o), int'(exp_addr(1'b0, NADDR - 2)));
    for (int k = 2; k < NADDR; k++) step(0);
    check("R7", "final desc addr", int'(addr_o), 0);
    check("R7", "final desc last", int'(addr_last_o), 1);
    step(0);
    check("R8", "desc held addr", int'(addr_o), 0);

    // R9: restart mid-pass in the other order; R11: start with advance
    pulse_start(1'b0, 1'b0);
    repeat (5) step(0);
    check("R9", "mid addr", int'(addr_o), 5 ^ (5 >> 1));
    pulse_start(1'b1, 1'b1);
    check("R11", "start beats advance", int'(addr_o), 1 << (W - 1));
    repeat (3) step(0);
    pulse_start(1'b0, 1'b1);
    check("R9", "restart ascending", int'(addr_o), 0);
    step(0);
    check("R3", "one step", int'(addr_o), 1);

    repeat (3) @(negedge clk);
    summary();
  end

endmodule